// File: doc/BRIEF.md
# Single-Wire Manchester Bus Master

This block is the controlling end of a half-duplex serial bus that uses one wire. Clock and data travel together on that wire as Manchester-coded bits. The block drives the wire through an output value and an output enable. When the enable is low, an external pull-up holds the wire high. The block also samples the wire, so it can see the short replies that a slave puts on it.

A host starts a command with a one-cycle `start` pulse. The block then does the following in order:
- It either drives the wire high for a long standby interval, or leaves it released for a short idle gap.
- It pulls the wire low for a header pulse and sends the synchronisation byte 0x55.
- It sends the bytes that the host offers on a valid/ready port. The address byte or bytes come first, then the payload.

Each byte is followed by a two-bit acknowledge slot. In the first bit the master says whether the command continues. In the second bit the master releases the wire and looks for the slave's reply. The block reports each reply that it checks, and at the end it reports that the command is done and whether it failed.

The bit period is set in system clocks and is captured when the command starts. A command that sends one address byte marked last polls for a device: an acknowledge means a device answers at that address.

Top module: `mbm_master`

## Requirements
- R1: Each bit lasts `bit_cycles` clocks. The wire is driven to the inverse of the bit value for the first `bit_cycles/2` clocks and to the bit value for the rest, so a '1' has a rising mid-bit edge and a '0' a falling one.
- R2: After the header pulse, the block sends 0x55 and then each host byte, every byte most significant bit first, with no idle time between bits.
- R3: After each byte, the first acknowledge bit is '1' unless the byte was flagged last, in which case it is '0'. The byte 0x55 is always followed by '1'. For the second acknowledge bit, the output enable is low.
- R4: The wire is driven high for exactly STBY_CYC clocks before the header pulse in three cases: when `standby_req` is set at start, on the first command after reset, and on the first command after a command that ended with an error. In every other case the block never drives the wire high before the header.
- R5: Without a standby interval, the wire stays released for at least SS_CYC clocks before the header. The header pulse drives the wire low for exactly HDR_CYC clocks.
- R6: No reply is reported for the slot after 0x55. When `addr_wide` is set, no reply is reported for the slot after the first host byte either. Every other slot gives exactly one `ack_stb` pulse.
- R7: A reply counts only as a rising wire edge within ±`bit_cycles/4` of the middle of the second acknowledge bit. A rising edge at the start of that bit (after a '0' first bit) does not count. When a checked slot has no reply, `ack_ok` is 0 and `done` and `error` rise together, the wire stays released, and no further byte is sent.
- R8: A byte flagged last ends the command after its slot. When its reply was seen, `done` is pulsed with `error` low; this serves as address polling.
- R9: If no host byte has been accepted by the end of a slot whose first bit was '1', the command ends with `done` and `error`.
- R10: Changing `bit_cycles` after `start` has no effect on the command in progress.
- R11: `tx_ready` is high only in the second acknowledge bit of a continuing byte, while no next byte is held. After reset the wire is released and `tx_ready` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a command while idle |
| standby_req | input | 1 | Request the long standby interval for this command |
| addr_wide | input | 1 | The address uses two host bytes; the slot after the first one is not checked |
| bit_cycles | input | BW | Bit period in clocks, captured at start |
| tx_data | input | 8 | Next host byte |
| tx_last | input | 1 | The offered byte ends the command |
| tx_valid | input | 1 | The host offers a byte |
| tx_ready | output | 1 | The block accepts the offered byte this cycle |
| line_in | input | 1 | Sampled wire level |
| line_out | output | 1 | Level driven when enabled |
| line_oe | output | 1 | Output enable for the wire |
| ack_stb | output | 1 | One-cycle pulse at the end of each checked acknowledge slot |
| ack_ok | output | 1 | A reply was seen in that slot |
| done | output | 1 | One-cycle pulse when the command ends |
| error | output | 1 | The command that just ended failed; valid with done |

## Verification
The bench targets the acknowledge slot that follows a '0' first bit. There the wire rises by itself as soon as it is released. A detector without the timing window would report a reply from an absent device, and the failed polling case would then report success. The bench also checks two slots that must not be reported: the one after the synchronisation byte, where the bench slave replies on purpose, and the one after the first of two address bytes. A design that checks those slots produces an extra `ack_stb`. The bench confirms that the standby interval is forced after reset and after a failure even when it is not requested; a design that forgets this skips the interval. It also changes `bit_cycles` in the middle of a command, which corrupts the decoded bytes if the period is not captured at start.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_STBY, S_GAP, S_HDR, S_DATA, S_MAK, S_SAK
  } state_t;

  typedef enum logic [1:0] {
    DRV_REL, DRV_HI, DRV_LO, DRV_MAN
  } drv_t;

  localparam logic [7:0] SYNC_BYTE = 8'h55;
endpackage

// File: rtl/mbm_phase.sv
module mbm_phase #(
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [BW-1:0] period,
  output logic [BW-1:0] phase,
  output logic          bit_end,
  output logic          first_half,
  output logic          mid,
  output logic          in_win
);
  logic [BW-1:0] half, quarter;

  assign half       = period >> 1;
  assign quarter    = period >> 2;
  assign bit_end    = run && (phase == period - 1'b1);
  assign first_half = phase < half;
  assign mid        = run && (phase == half);
  assign in_win     = (phase >= half - quarter) && (phase <= half + quarter);

  always_ff @(posedge clk) begin
    if (rst || !run)  phase <= '0;
    else if (bit_end) phase <= '0;
    else              phase <= phase + 1'b1;
  end

  // R10: the phase never leaves the captured period
  a_r10_phase_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (phase < period));
endmodule

// File: rtl/mbm_drive.sv
module mbm_drive
  import mbm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  drv_t mode,
  input  logic bit_val,
  input  logic first_half,
  input  logic mid,
  output logic line_out,
  output logic line_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b1;
      line_oe  <= 1'b0;
    end else begin
      unique case (mode)
        DRV_REL: begin line_oe <= 1'b0; line_out <= 1'b1; end
        DRV_HI:  begin line_oe <= 1'b1; line_out <= 1'b1; end
        DRV_LO:  begin line_oe <= 1'b1; line_out <= 1'b0; end
        DRV_MAN: begin line_oe <= 1'b1; line_out <= first_half ? ~bit_val : bit_val; end
      endcase
    end
  end

  // R1: every coded bit toggles the wire at its middle
  a_r1_mid_edge: assert property (@(posedge clk) disable iff (rst)
    (mode == DRV_MAN && mid) |=> (line_out != $past(line_out)));
endmodule

// File: rtl/mbm_sak.sv
module mbm_sak (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic slot,
  input  logic in_win,
  output logic seen
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      seen <= 1'b0;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      if (!slot)                    seen <= 1'b0;
      else if (in_win && s1 && !s2) seen <= 1'b1;
    end
  end

  // R7: a reply is only taken inside the mid-bit window
  a_r7_window_only: assert property (@(posedge clk) disable iff (rst)
    $rose(seen) |-> $past(in_win));
endmodule

// File: rtl/mbm_master.sv
module mbm_master
  import mbm_pkg::*;
#(
  parameter int BW       = 16,
  parameter int STBY_CYC = 150000,
  parameter int SS_CYC   = 2500,
  parameter int HDR_CYC  = 1250
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          standby_req,
  input  logic          addr_wide,
  input  logic [BW-1:0] bit_cycles,
  input  logic [7:0]    tx_data,
  input  logic          tx_last,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic          line_in,
  output logic          line_out,
  output logic          line_oe,
  output logic          ack_stb,
  output logic          ack_ok,
  output logic          done,
  output logic          error
);
  localparam int TMAX = (STBY_CYC > SS_CYC) ?
                        ((STBY_CYC > HDR_CYC) ? STBY_CYC : HDR_CYC) :
                        ((SS_CYC > HDR_CYC) ? SS_CYC : HDR_CYC);
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [TW-1:0] STBY_LAST = TW'(STBY_CYC - 1);
  localparam logic [TW-1:0] SS_LAST   = TW'(SS_CYC - 1);
  localparam logic [TW-1:0] HDR_LAST  = TW'(HDR_CYC - 1);

  state_t        state;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] period_q, phase;
  logic [7:0]    sh, nxt_q;
  logic [2:0]    bidx;
  logic [1:0]    byte_idx;
  logic          wide_q, mak_q, nxt_last, have_next, need_stby;
  logic          run, bit_end, first_half, mid, in_win, sak_seen, checked;
  drv_t          mode;
  logic          drv_bit;

  assign run      = (state == S_DATA) || (state == S_MAK) || (state == S_SAK);
  assign checked  = (byte_idx != 2'd0) && !(wide_q && byte_idx == 2'd1);
  assign tx_ready = (state == S_SAK) && mak_q && !have_next && !bit_end;

  mbm_phase #(.BW(BW)) u_phase (
    .clk(clk), .rst(rst), .run(run), .period(period_q), .phase(phase),
    .bit_end(bit_end), .first_half(first_half), .mid(mid), .in_win(in_win)
  );

  mbm_sak u_sak (
    .clk(clk), .rst(rst), .line_in(line_in), .slot(state == S_SAK),
    .in_win(in_win), .seen(sak_seen)
  );

  always_comb begin
    mode    = DRV_REL;
    drv_bit = 1'b1;
    unique case (state)
      S_STBY:  mode = DRV_HI;
      S_HDR:   mode = DRV_LO;
      S_DATA:  begin mode = DRV_MAN; drv_bit = sh[7]; end
      S_MAK:   begin mode = DRV_MAN; drv_bit = mak_q; end
      default: mode = DRV_REL;
    endcase
  end

  mbm_drive u_drive (
    .clk(clk), .rst(rst), .mode(mode), .bit_val(drv_bit),
    .first_half(first_half), .mid(mid), .line_out(line_out), .line_oe(line_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      tcnt      <= '0;
      period_q  <= '0;
      sh        <= '0;
      nxt_q     <= '0;
      nxt_last  <= 1'b0;
      bidx      <= '0;
      byte_idx  <= '0;
      wide_q    <= 1'b0;
      mak_q     <= 1'b0;
      have_next <= 1'b0;
      need_stby <= 1'b1;
      ack_stb   <= 1'b0;
      ack_ok    <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      done    <= 1'b0;
      ack_stb <= 1'b0;
      if (tx_valid && tx_ready) begin
        nxt_q     <= tx_data;
        nxt_last  <= tx_last;
        have_next <= 1'b1;
      end
      unique case (state)
        S_IDLE: if (start) begin
          period_q  <= bit_cycles;
          wide_q    <= addr_wide;
          tcnt      <= '0;
          have_next <= 1'b0;
          error     <= 1'b0;
          if (standby_req || need_stby) begin
            state     <= S_STBY;
            need_stby <= 1'b0;
          end else begin
            state <= S_GAP;
          end
        end
        S_STBY: if (tcnt == STBY_LAST) begin tcnt <= '0; state <= S_HDR; end
                else tcnt <= tcnt + 1'b1;
        S_GAP:  if (tcnt == SS_LAST) begin tcnt <= '0; state <= S_HDR; end
                else tcnt <= tcnt + 1'b1;
        S_HDR:  if (tcnt == HDR_LAST) begin
          tcnt     <= '0;
          sh       <= SYNC_BYTE;
          bidx     <= '0;
          byte_idx <= '0;
          mak_q    <= 1'b1;
          state    <= S_DATA;
        end else tcnt <= tcnt + 1'b1;
        S_DATA: if (bit_end) begin
          if (bidx == 3'd7) state <= S_MAK;
          else begin
            sh   <= {sh[6:0], 1'b0};
            bidx <= bidx + 1'b1;
          end
        end
        S_MAK: if (bit_end) state <= S_SAK;
        S_SAK: if (bit_end) begin
          if (checked) begin
            ack_stb <= 1'b1;
            ack_ok  <= sak_seen;
          end
          if ((checked && !sak_seen) || (mak_q && !have_next)) begin
            done      <= 1'b1;
            error     <= 1'b1;
            need_stby <= 1'b1;
            state     <= S_IDLE;
          end else if (!mak_q) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            sh        <= nxt_q;
            mak_q     <= ~nxt_last;
            have_next <= 1'b0;
            bidx      <= '0;
            byte_idx  <= (byte_idx == 2'd2) ? 2'd2 : byte_idx + 2'd1;
            state     <= S_DATA;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: the second acknowledge bit leaves the wire to the slave
  a_r3_release_slot: assert property (@(posedge clk) disable iff (rst)
    (state == S_SAK) |=> !line_oe);
  // R4: standby drives the wire high
  a_r4_stby_high: assert property (@(posedge clk) disable iff (rst)
    (state == S_STBY) |=> (line_oe && line_out));
  // R5: header pulse drives the wire low
  a_r5_hdr_low: assert property (@(posedge clk) disable iff (rst)
    (state == S_HDR) |=> (line_oe && !line_out));
  // R7: a missing reply ends the command with an error
  a_r7_fail_ends: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && !ack_ok) |-> (done && error));
  // R10: the captured period holds for the whole command
  a_r10_period_hold: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(period_q));
endmodule

// File: tb/mbm_master_test.sv
module mbm_master_test;
  localparam int BW = 16, STBY = 200, SS = 40, HDR = 20;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic start = 0, standby_req = 0, addr_wide = 0;
  logic [BW-1:0] bit_cycles = 16;
  logic [7:0] tx_data = 0;
  logic tx_last = 0, tx_valid = 0, tx_ready;
  logic line_out, line_oe, ack_stb, ack_ok, done, error;
  logic slave_low = 0;
  logic line;
  assign line = line_oe ? line_out : ~slave_low;

  mbm_master #(.BW(BW), .STBY_CYC(STBY), .SS_CYC(SS), .HDR_CYC(HDR)) uut (
    .clk(clk), .rst(rst), .start(start), .standby_req(standby_req),
    .addr_wide(addr_wide), .bit_cycles(bit_cycles), .tx_data(tx_data),
    .tx_last(tx_last), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .line_in(line), .line_out(line_out), .line_oe(line_oe),
    .ack_stb(ack_stb), .ack_ok(ack_ok), .done(done), .error(error)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] host_q[$];
  bit         slave_q[$];
  logic [8:0] wire_q[$];
  bit         ack_q[$];
  bit mark_last = 1, pend = 0, prev_oe = 0;
  int cur_p = 16, scnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // host byte driver
  always @(negedge clk) begin
    if (pend && host_q.size() > 0) void'(host_q.pop_front());
    tx_valid = host_q.size() > 0;
    tx_data  = (host_q.size() > 0) ? host_q[0] : 8'h00;
    tx_last  = mark_last && host_q.size() == 1;
    pend     = tx_valid && tx_ready;
  end

  // slave model: reply with a mid-bit rising edge when planned
  always @(negedge clk) begin
    bit r;
    if (scnt > 0) begin
      scnt--;
      if (scnt == 0) slave_low = 0;
    end
    if (prev_oe && !line_oe) begin
      r = (slave_q.size() > 0) ? slave_q.pop_front() : 1'b0;
      if (r) begin slave_low = 1; scnt = cur_p / 2; end
    end
    prev_oe = line_oe;
  end

  // scoreboard for acknowledge reports (R6, R7)
  always @(negedge clk) begin
    bit e;
    if (!rst && ack_stb) begin
      if (ack_q.size() == 0) check(0, "R6 unexpected ack report", 1, 0);
      else begin
        e = ack_q.pop_front();
        check(ack_ok == e, "R7 ack value", int'(ack_ok), int'(e));
      end
    end
  end

  // wire monitor: lead-in, header pulse and decoded byte groups
  task automatic watch(input int p, input bit exp_stby);
    int hi = 0, tot = 0, lo = 0;
    logic [8:0] e, v;
    logic a, b;
    bit good;
    while (!(line_oe && !line_out)) begin
      if (line_oe && line_out) hi++;
      tot++;
      @(negedge clk);
    end
    while (line_oe && !line_out) begin lo++; @(negedge clk); end
    check(lo == HDR, "R5 header low length", lo, HDR);
    if (exp_stby) check(hi == STBY, "R4 standby length", hi, STBY);
    else begin
      check(hi == 0, "R4 no standby drive", hi, 0);
      check(tot >= SS, "R5 idle gap", tot, SS);
    end
    while (wire_q.size() > 0) begin
      e = wire_q.pop_front();
      v = '0;
      good = 1;
      for (int k = 0; k < 9; k++) begin
        repeat (p / 4) @(negedge clk);
        a = line;
        repeat (p / 2) @(negedge clk);
        b = line;
        repeat (p - p / 4 - p / 2) @(negedge clk);
        if (a == b) good = 0;
        v = {v[7:0], b};
      end
      check(good, "R1 mid-bit edge", int'(v), int'(e));
      check(v[8:1] == e[8:1], "R2 byte value", int'(v[8:1]), int'(e[8:1]));
      check(v[0] == e[0], "R3 first ack bit", int'(v[0]), int'(e[0]));
      repeat (p) @(negedge clk);
    end
  endtask

  task automatic run_cmd(input bit req, input bit wide, input int p, input int p_alt,
                         input bit exp_stby, input bit exp_err, input string etag);
    cur_p = p;
    @(negedge clk);
    standby_req = req; addr_wide = wide; bit_cycles = BW'(p); start = 1;
    @(negedge clk);
    start = 0;
    if (p_alt != 0) bit_cycles = BW'(p_alt);
    fork
      watch(p, exp_stby);
      begin
        while (!done) @(negedge clk);
        check(error == exp_err, etag, int'(error), int'(exp_err));
      end
    join
    @(negedge clk);
    check(ack_q.size() == 0, "R6 missing ack report", ack_q.size(), 0);
    check(!line_oe, "R7 wire released after end", int'(line_oe), 0);
    repeat (4) @(negedge clk);
    host_q.delete(); slave_q.delete(); wire_q.delete(); ack_q.delete();
    mark_last = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!line_oe && !tx_ready && !done, "R11 reset state",
          int'({line_oe, tx_ready, done}), 0);

    // T1: forced standby after reset, payload, header slot reply ignored (R4, R6, R8)
    host_q = '{8'hA0, 8'h03, 8'h5C};
    slave_q = '{1, 1, 1, 1};
    wire_q = '{{8'h55, 1'b1}, {8'hA0, 1'b1}, {8'h03, 1'b1}, {8'h5C, 1'b0}};
    ack_q = '{1, 1, 1};
    run_cmd(0, 0, 16, 0, 1, 0, "R8 command ends clean");

    // T2: idle gap, polling hit, period changed mid-command (R5, R8, R10)
    host_q = '{8'h96};
    slave_q = '{0, 1};
    wire_q = '{{8'h55, 1'b1}, {8'h96, 1'b0}};
    ack_q = '{1};
    run_cmd(0, 0, 24, 40, 0, 0, "R10 R8 polling hit");

    // T3: polling miss: rising edge at slot start must not count (R7)
    host_q = '{8'h97};
    slave_q = '{0, 0};
    wire_q = '{{8'h55, 1'b1}, {8'h97, 1'b0}};
    ack_q = '{0};
    run_cmd(0, 0, 16, 0, 0, 1, "R7 polling miss error");

    // T4: standby forced after error, wide address (R4, R6)
    host_q = '{8'hF1, 8'h2B, 8'h77};
    slave_q = '{0, 0, 1, 1};
    wire_q = '{{8'h55, 1'b1}, {8'hF1, 1'b1}, {8'h2B, 1'b1}, {8'h77, 1'b0}};
    ack_q = '{1, 1};
    run_cmd(0, 1, 20, 0, 1, 0, "R6 wide address clean");

    // T5: reply missing mid-command aborts (R7)
    host_q = '{8'h50, 8'h11, 8'h22, 8'h33};
    slave_q = '{0, 1, 0};
    wire_q = '{{8'h55, 1'b1}, {8'h50, 1'b1}, {8'h11, 1'b1}};
    ack_q = '{1, 0};
    run_cmd(1, 0, 16, 0, 1, 1, "R7 missing reply error");

    // T6: host underrun (R9, R11)
    mark_last = 0;
    host_q = '{8'h5A, 8'h66};
    slave_q = '{0, 1, 1};
    wire_q = '{{8'h55, 1'b1}, {8'h5A, 1'b1}, {8'h66, 1'b1}};
    ack_q = '{1, 1};
    run_cmd(1, 0, 16, 0, 1, 1, "R9 underrun error");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule